// File: doc/BRIEF.md
# ADC Clock Source Selector and Gate

This block decides which clock an ADC core receives and when that clock runs. It has two sources. The conversion clock comes from the bus clock through a programmable divisor. The standby clock comes from a free-running oscillator input that is divided by a fixed ratio. All logic runs in the bus clock domain. The oscillator is synchronised and edge-detected. The chosen clock leaves the block as a one-cycle enable pulse, `adc_clk_en`, together with a source indicator and a gate indicator. The bus clock must run at least twice as fast as the oscillator.

A four-state machine sequences the clock.
- `ST_OFF`: the clock is gated.
- `ST_PWRUP`: the power-up window. The conversion clock runs while a delay counter counts down.
- `ST_RUN`: the conversion clock runs after power-up has completed.
- `ST_STBY`: the standby clock runs while both converters idle in auto-standby mode.

The transitions are:
- **wake**: `ST_OFF` or `ST_STBY` to `ST_PWRUP`. Taken on a start request, a busy converter, or a mode that keeps the clock running. The delay counter is loaded on this transition.
- **powered**: `ST_PWRUP` to `ST_RUN`. Taken when the delay counter is zero and no start request is present.
- **scan-finished**: `ST_RUN` to `ST_STBY` or `ST_OFF`. Taken only in the auto modes, after a scan-done pulse, with every converter idle.
- **doze**: `ST_OFF` to `ST_STBY`. Taken in auto-standby mode.
- **sleep**: `ST_STBY` to `ST_OFF`. Taken in auto-power-down mode.

A change of source waits for a cycle with no clock pulse, so no shortened period reaches the ADC.

Top module: `adcclk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `adc_clk_en`, `adc_clk_sel`, `adc_clk_on` and `pwrup_done` are all 0.
- R2: While the conversion source is selected (`adc_clk_sel`=0), consecutive `adc_clk_en` pulses are exactly 2×(`div_val`+1) bus cycles apart, and two pulses never occur in adjacent cycles.
- R3: After a wake-up, exactly `pud_val` conversion pulses are delivered before `pwrup_done` rises. `pwrup_done` is high only with the clock on and the conversion source selected.
- R4: A `start` pulse during the power-up window reloads the delay, so the pulses before `pwrup_done` total the pulses already delivered plus `pud_val`.
- R5: With `pwr_mode` 2'b00 (normal), 2'b11 (treated as normal), or `loop_mode`=1, the clock stays on with the conversion source and `pwrup_done` high after a scan-done pulse.
- R6: With `pwr_mode` 2'b01 (auto-standby), a scan-done pulse with all converters idle switches to the standby source (`adc_clk_sel`=1). Its pulses are 80 oscillator periods apart.
- R7: With `pwr_mode` 2'b10 (auto-power-down), a scan-done pulse with all converters idle gates the clock: `adc_clk_on`=0 and no `adc_clk_en` pulses. The clock then stays gated until a start request, a busy flag or a mode change.
- R8: Any `busy` bit set while on the standby source returns the block to the conversion source and restarts the power-up window.
- R9: A scan-done pulse that arrives while a converter is busy keeps the conversion clock running. The clock stops or falls back once all `busy` bits are clear.
- R10: `adc_clk_sel` changes only when there is no `adc_clk_en` pulse in the cycle of the change or in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock, standby source |
| pwr_mode | input | 2 | 00 normal, 01 auto-standby, 10 auto-power-down, 11 as normal |
| loop_mode | input | 1 | Continuous scan mode active |
| start | input | 1 | Conversion start request pulse |
| busy | input | NCONV | Per-converter busy flags |
| scan_done | input | 1 | Scan-complete pulse |
| div_val | input | DIV_W | Conversion divisor field |
| pud_val | input | PUD_W | Power-up delay, in conversion pulses |
| adc_clk_en | output | 1 | One-cycle ADC clock pulse |
| adc_clk_sel | output | 1 | 0 conversion source, 1 standby source |
| adc_clk_on | output | 1 | ADC clock not gated |
| pwrup_done | output | 1 | Power-up delay expired, clock in run state |

## Verification
The main sequence is a wake-up followed by a scan-done pulse. It is tried with every power mode, with loop mode set against auto-power-down, and with divisors from 0 to the maximum. Delays include zero and one, so that an off-by-one in either counter shows up as a wrong pulse count or spacing. The final state after scan-done separates the three exit routes: continued run, fall-back to standby with its 80-period spacing, and full gating. Directed cases then inject a start request in mid-window and a busy flag in standby. They also send a scan-done pulse under a busy flag, which separates reload, forced source return and deferred shutdown from the plain sequence.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL    = 2'b00,
        PM_AUTO_STBY = 2'b01,
        PM_AUTO_PDN  = 2'b10,
        PM_RSVD      = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PWRUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_STBY  = 2'd3
    } clk_state_e;

endpackage

// File: rtl/adcclk_conv_div.sv
// Conversion clock divider: one enable pulse every 2*(div+1) bus cycles.
// The count is held at zero while not running, so the first pulse after
// a start always follows a full period.
module adcclk_conv_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    assign term = {div_val, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q >= term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == term);

endmodule

// File: rtl/adcclk_stby_div.sv
// Standby clock divider: synchronises the oscillator into the bus domain
// and emits one pulse for every STBY_DIV oscillator rising edges.
module adcclk_stby_div #(
    parameter int STBY_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(STBY_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STBY_DIV - 1);

    logic [2:0]       sync_q;
    logic             osc_rise;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], osc_clk};
        end
    end

    assign osc_rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (osc_rise) begin
            if (cnt_q >= LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = run && osc_rise && (cnt_q == LAST);

endmodule

// File: rtl/adcclk_pud_cnt.sv
// Power-up delay counter: loads the programmed delay and counts down
// once per conversion pulse until it reaches zero.
module adcclk_pud_cnt #(
    parameter int PUD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PUD_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [PUD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adcclk_fsm.sv
// Clock sequencing state machine.
module adcclk_fsm
    import adcclk_pkg::*;
#(
    parameter int NCONV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwr_mode_e        pwr_mode,
    input  logic             loop_mode,
    input  logic             start,
    input  logic [NCONV-1:0] busy,
    input  logic             scan_done,
    input  logic             pud_zero,
    input  logic             clk_tick,
    output clk_state_e       state,
    output logic             pud_load,
    output logic             conv_run,
    output logic             stby_run,
    output logic             clk_on,
    output logic             clk_sel,
    output logic             pwrup_done
);
    clk_state_e state_q;
    clk_state_e state_d;
    logic       scan_seen_q;
    logic       always_run;
    logic       any_busy;
    logic       wake;
    logic       scan_end;

    assign always_run = (pwr_mode == PM_NORMAL) || (pwr_mode == PM_RSVD) || loop_mode;
    assign any_busy   = |busy;
    assign wake       = always_run || start || any_busy;
    assign scan_end   = (scan_seen_q || scan_done) && !any_busy && !start && !always_run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // scan-done memory, held while in run state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_seen_q <= 1'b0;
        end else if (state_d != ST_RUN) begin
            scan_seen_q <= 1'b0;
        end else if (state_q == ST_RUN && scan_done) begin
            scan_seen_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wake) begin
                    state_d = ST_PWRUP;
                end else if (pwr_mode == PM_AUTO_STBY) begin
                    state_d = ST_STBY;
                end
            end
            ST_STBY: begin
                if (!clk_tick) begin
                    if (wake) begin
                        state_d = ST_PWRUP;
                    end else if (pwr_mode != PM_AUTO_STBY) begin
                        state_d = ST_OFF;
                    end
                end
            end
            ST_PWRUP: begin
                if (pud_zero && !start) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (scan_end && !clk_tick) begin
                    state_d = (pwr_mode == PM_AUTO_STBY) ? ST_STBY : ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        pud_load   = 1'b0;
        conv_run   = 1'b0;
        stby_run   = 1'b0;
        clk_on     = 1'b0;
        clk_sel    = 1'b0;
        pwrup_done = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                pud_load = wake;
            end
            ST_STBY: begin
                pud_load = wake && !clk_tick;
                stby_run = 1'b1;
                clk_on   = 1'b1;
                clk_sel  = 1'b1;
            end
            ST_PWRUP: begin
                pud_load = start;
                conv_run = 1'b1;
                clk_on   = 1'b1;
            end
            ST_RUN: begin
                conv_run   = 1'b1;
                clk_on     = 1'b1;
                pwrup_done = 1'b1;
            end
            default: begin
                pud_load = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/adcclk_gate_ctrl.sv
// Top: ADC clock source selection and gating.
module adcclk_gate_ctrl
    import adcclk_pkg::*;
#(
    parameter int NCONV    = 2,
    parameter int DIV_W    = 4,
    parameter int PUD_W    = 6,
    parameter int STBY_DIV = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_clk,
    input  logic [1:0]       pwr_mode,
    input  logic             loop_mode,
    input  logic             start,
    input  logic [NCONV-1:0] busy,
    input  logic             scan_done,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PUD_W-1:0] pud_val,
    output logic             adc_clk_en,
    output logic             adc_clk_sel,
    output logic             adc_clk_on,
    output logic             pwrup_done
);
    clk_state_e state;
    logic       pud_load;
    logic       pud_zero;
    logic       conv_run;
    logic       stby_run;
    logic       conv_tick;
    logic       stby_tick;
    logic       clk_tick;

    assign clk_tick = conv_tick | stby_tick;

    adcclk_conv_div #(.DIV_W(DIV_W)) u_conv_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (conv_run),
        .div_val (div_val),
        .tick    (conv_tick)
    );

    adcclk_stby_div #(.STBY_DIV(STBY_DIV)) u_stby_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_clk (osc_clk),
        .run     (stby_run),
        .tick    (stby_tick)
    );

    adcclk_pud_cnt #(.PUD_W(PUD_W)) u_pud_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pud_load),
        .load_val (pud_val),
        .dec      (conv_tick),
        .zero     (pud_zero)
    );

    adcclk_fsm #(.NCONV(NCONV)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_mode   (pwr_mode_e'(pwr_mode)),
        .loop_mode  (loop_mode),
        .start      (start),
        .busy       (busy),
        .scan_done  (scan_done),
        .pud_zero   (pud_zero),
        .clk_tick   (clk_tick),
        .state      (state),
        .pud_load   (pud_load),
        .conv_run   (conv_run),
        .stby_run   (stby_run),
        .clk_on     (adc_clk_on),
        .clk_sel    (adc_clk_sel),
        .pwrup_done (pwrup_done)
    );

    assign adc_clk_en = clk_tick;

endmodule

// File: rtl/adcclk_gate_ctrl_chk.sv
module adcclk_gate_ctrl_chk #(
    parameter int NCONV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pwr_mode,
    input logic             loop_mode,
    input logic             start,
    input logic [NCONV-1:0] busy,
    input logic             adc_clk_en,
    input logic             adc_clk_sel,
    input logic             adc_clk_on,
    input logic             pwrup_done
);
    logic keep_running;
    assign keep_running = (pwr_mode == 2'b00) || (pwr_mode == 2'b11) || loop_mode;

    AST_CONV_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_clk_en && !adc_clk_sel) |=> !adc_clk_en); // R2

    AST_DONE_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_done |-> (adc_clk_on && !adc_clk_sel)); // R3

    AST_KEEP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrup_done && keep_running) |=> pwrup_done); // R5

    AST_PDN_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_clk_on && pwr_mode == 2'b10 && !loop_mode && !start && busy == '0)
        |=> (!adc_clk_on && !adc_clk_en)); // R7

    AST_BUSY_LEAVES_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_clk_sel && (|busy) && !adc_clk_en) |=> !adc_clk_sel); // R8

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_clk_sel) |-> (!adc_clk_en && !$past(adc_clk_en))); // R10

endmodule

bind adcclk_gate_ctrl adcclk_gate_ctrl_chk #(.NCONV(NCONV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_mode    (pwr_mode),
    .loop_mode   (loop_mode),
    .start       (start),
    .busy        (busy),
    .adc_clk_en  (adc_clk_en),
    .adc_clk_sel (adc_clk_sel),
    .adc_clk_on  (adc_clk_on),
    .pwrup_done  (pwrup_done)
);

// File: tb/adcclk_gate_ctrl_tb.sv
module adcclk_gate_ctrl_tb;
    localparam int NCONV     = 2;
    localparam int DIV_W     = 4;
    localparam int PUD_W     = 6;
    localparam int STBY_DIV  = 80;
    localparam int OSC_RATIO = 4;   // osc period / bus period

    logic             clk = 1'b0;
    logic             osc_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       pwr_mode = 2'b00;
    logic             loop_mode = 1'b0;
    logic             start = 1'b0;
    logic [NCONV-1:0] busy = '0;
    logic             scan_done = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic [PUD_W-1:0] pud_val = '0;
    logic             adc_clk_en;
    logic             adc_clk_sel;
    logic             adc_clk_on;
    logic             pwrup_done;

    always #4 clk = ~clk;
    always #16 osc_clk = ~osc_clk;

    adcclk_gate_ctrl #(
        .NCONV(NCONV), .DIV_W(DIV_W), .PUD_W(PUD_W), .STBY_DIV(STBY_DIV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .pwr_mode(pwr_mode),
        .loop_mode(loop_mode), .start(start), .busy(busy), .scan_done(scan_done),
        .div_val(div_val), .pud_val(pud_val), .adc_clk_en(adc_clk_en),
        .adc_clk_sel(adc_clk_sel), .adc_clk_on(adc_clk_on), .pwrup_done(pwrup_done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // mode, loop, divisor, delay, outcome after scan-done (0 run, 1 standby, 2 gated)
    typedef struct packed {
        logic [1:0] mode;
        logic       lp;
        logic [3:0] div;
        logic [5:0] pud;
        logic [1:0] after;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 4'd0,  6'd3, 2'd0},
        '{2'd0, 1'b0, 4'd3,  6'd5, 2'd0},
        '{2'd1, 1'b0, 4'd1,  6'd2, 2'd1},
        '{2'd2, 1'b0, 4'd2,  6'd4, 2'd2},
        '{2'd2, 1'b1, 4'd1,  6'd3, 2'd0},
        '{2'd3, 1'b0, 4'd5,  6'd0, 2'd0},
        '{2'd1, 1'b0, 4'd15, 6'd1, 2'd1}
    };

    task automatic boot(input logic [1:0] m, input logic lp, input logic [3:0] d, input logic [5:0] p);
        rst_n = 1'b0; start = 1'b0; busy = '0; scan_done = 1'b0;
        pwr_mode = m; loop_mode = lp; div_val = d; pud_val = p;
        repeat (3) @(negedge clk);
        chk(!adc_clk_en && !adc_clk_sel && !adc_clk_on && !pwrup_done, "R1 reset outputs",
            {adc_clk_en, adc_clk_sel, adc_clk_on, pwrup_done}, 0);
        rst_n = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic count_to_done(input int period, output int n, output int badgap);
        int cyc = 0;
        int last = -1;
        n = 0; badgap = 0;
        while (!pwrup_done && cyc < 20000) begin
            if (adc_clk_en) begin
                n++;
                if (last >= 0 && (cyc - last) != period) badgap++;
                last = cyc;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic measure_gap(input logic want_sel, output int gap);
        int cyc = 0;
        gap = -1;
        while (!(adc_clk_en && adc_clk_sel == want_sel) && cyc < 3000) begin
            @(negedge clk); cyc++;
        end
        if (cyc < 3000) begin
            cyc = 0;
            @(negedge clk); cyc++;
            while (!(adc_clk_en && adc_clk_sel == want_sel) && cyc < 3000) begin
                @(negedge clk); cyc++;
            end
            if (cyc < 3000) gap = cyc;
        end
    endtask

    task automatic pulse_scan_done();
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n, bad, gap, quiet;

        // table-driven main sequence
        for (int i = 0; i < NVEC; i++) begin
            boot(VECS[i].mode, VECS[i].lp, VECS[i].div, VECS[i].pud);
            count_to_done(2 * (VECS[i].div + 1), n, bad);
            chk(pwrup_done == 1'b1, "R3 done reached", pwrup_done, 1);
            chk(n == VECS[i].pud, "R3 pulses before done", n, VECS[i].pud);
            chk(bad == 0, "R2 power-up spacing", bad, 0);
            measure_gap(1'b0, gap);
            chk(gap == 2 * (VECS[i].div + 1), "R2 run spacing", gap, 2 * (VECS[i].div + 1));
            pulse_scan_done();
            repeat (4) @(negedge clk);
            if (VECS[i].after == 2'd0) begin
                chk(adc_clk_on && !adc_clk_sel && pwrup_done, "R5 keeps running",
                    {adc_clk_on, adc_clk_sel, pwrup_done}, 3'b101);
            end else if (VECS[i].after == 2'd1) begin
                chk(adc_clk_on && adc_clk_sel && !pwrup_done, "R6 standby source",
                    {adc_clk_on, adc_clk_sel, pwrup_done}, 3'b110);
                measure_gap(1'b1, gap);
                chk(gap == STBY_DIV * OSC_RATIO, "R6 standby spacing", gap, STBY_DIV * OSC_RATIO);
            end else begin
                quiet = 0;
                for (int c = 0; c < 400; c++) begin
                    if (adc_clk_en) quiet++;
                    @(negedge clk);
                end
                chk(!adc_clk_on, "R7 gated", adc_clk_on, 0);
                chk(quiet == 0, "R7 no pulses", quiet, 0);
            end
        end

        // R4: start in mid-window reloads the delay
        boot(2'd0, 1'b0, 4'd1, 6'd4);
        n = 0;
        while (n < 2) begin
            if (adc_clk_en) n++;
            @(negedge clk);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        count_to_done(4, gap, bad);
        chk(n + gap == 6, "R4 reload total pulses", n + gap, 6);

        // R8: busy while in standby returns to the conversion source
        boot(2'd1, 1'b0, 4'd1, 6'd2);
        count_to_done(4, n, bad);
        pulse_scan_done();
        repeat (4) @(negedge clk);
        chk(adc_clk_sel == 1'b1, "R8 standby before busy", adc_clk_sel, 1);
        busy = 2'b10;
        repeat (3) @(negedge clk);
        chk(!adc_clk_sel && adc_clk_on && !pwrup_done, "R8 conversion source on busy",
            {adc_clk_sel, adc_clk_on, pwrup_done}, 3'b010);
        count_to_done(4, n, bad);
        chk(n == 2, "R8 power-up restarted", n, 2);

        // R9: scan-done under busy keeps running until idle
        pulse_scan_done();
        repeat (20) @(negedge clk);
        chk(pwrup_done && !adc_clk_sel, "R9 held while busy", {pwrup_done, adc_clk_sel}, 2'b10);
        busy = '0;
        repeat (4) @(negedge clk);
        chk(adc_clk_sel && !pwrup_done, "R9 falls back when idle", {adc_clk_sel, pwrup_done}, 2'b10);

        // R9 in auto-power-down: gated once idle
        boot(2'd2, 1'b0, 4'd0, 6'd1);
        count_to_done(2, n, bad);
        busy = 2'b01;
        pulse_scan_done();
        repeat (10) @(negedge clk);
        chk(adc_clk_on == 1'b1, "R9 power-down held while busy", adc_clk_on, 1);
        busy = '0;
        repeat (4) @(negedge clk);
        chk(adc_clk_on == 1'b0, "R9 power-down gated when idle", adc_clk_on, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule